// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it takes an operation code, the accumulator value, a second operand (the memory byte, or the register a single-operand operation works on) and the carry flag as it stands. It produces a result byte, the next values of the overflow, half-carry, negative, zero and carry flags, and a per-flag write-enable mask. The surrounding core applies only the flags that are enabled and keeps the others, so each operation updates, forces or keeps flags in its own fixed way.

Two-operand operations take `acc_i` as the left operand and `opd_i` as the right one. Single-operand operations (complement, negate, increment, decrement, clear, test, shifts, rotates) work on `opd_i`, and the caller routes the accumulator, index register or memory byte to that port. The outputs are registered: they show the operation presented at the previous rising clock edge. A separate result-write strobe tells the core whether the result should be stored at all, because compare, bit test and test only set flags.

Top module: `alu8_core`

## Requirements
- R1: All outputs are registered and show the operation sampled at the previous rising edge of `clk`; while `rst_n` is low every output is 0.
- R2: Flag bits are ordered C=bit0, Z=bit1, N=bit2, H=bit3, V=bit4 in both `flags_q` and `fwe_q`; a flag bit whose enable is 0 reads 0. Codes: add 0, add-with-carry 1, subtract 2, subtract-with-borrow 3, compare 4, AND 5, OR 6, XOR 7, bit test 8, complement 9, negate 10, increment 11, decrement 12, clear 13, test 14, shift left 15, arithmetic shift right 16, logical shift right 17, rotate left 18, rotate right 19; codes 20 to 31 give result 0, no flag enable and no write.
- R3: Add computes acc+opd and add-with-carry acc+opd+C_in; both enable V, H, N, Z and C, with C the carry out of bit 7, H the carry out of bit 3 and V set when both operands share a sign the result does not have.
- R4: Subtract computes acc-opd, subtract-with-borrow acc-opd-C_in and compare acc-opd; all enable V, N, Z, C but not H, with C set on an unsigned borrow and V set when the operand signs differ and the result sign differs from acc.
- R5: `res_we_q` is 0 for compare, bit test, test and undefined codes and 1 for every other operation; `result_q` still carries the computed value when it is 0.
- R6: AND, OR, XOR and bit test (bit test computes AND) enable V, N and Z with V forced to 0; H and C are not enabled.
- R7: Complement gives FF-opd, forces V to 0 and C to 1, and enables V, N, Z and C.
- R8: Negate gives 00-opd with V set only for opd 80 and C set for any nonzero opd; it enables V, N, Z and C.
- R9: Increment gives opd+1 with V set only for opd 7F; decrement gives opd-1 with V set only for opd 80; both enable V, N and Z and never C.
- R10: Clear gives 00 with V 0, N 0, Z 1; test gives opd with V 0; both enable V, N and Z only.
- R11: Shift left moves bit 7 into C and fills bit 0 with 0; arithmetic shift right keeps bit 7 and logical shift right fills it with 0 (so N is 0); both right shifts move bit 0 into C.
- R12: Rotate left moves C_in into bit 0 and bit 7 into C; rotate right moves C_in into bit 7 and bit 0 into C.
- R13: For every shift and rotate V equals N XOR C of the result, and V, N, Z and C are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator (left) operand |
| opd_i | input | 8 | Second operand, or the operand of single-operand operations |
| cin_i | input | 1 | Current carry flag |
| result_q | output | 8 | Computed result |
| res_we_q | output | 1 | Result should be stored |
| flags_q | output | 5 | Next flag values {V,H,N,Z,C} |
| fwe_q | output | 5 | Per-flag write enables {V,H,N,Z,C} |

## Verification
The bench drives every operation with all pairs of 00, 7F, 80 and FF under both carry values, where the signed overflow boundary, carry out of bit 7 and borrow below zero all meet; a design that took overflow from the carry, or computed borrow as an inverted carry, fails there at once. Increment of 7F, decrement and negate of 80, and the half-carry of 0F+01 target the one-value overflow rules and the bit-3 carry that a wrong nibble boundary would miss. Compare, bit test and test are checked for a low write strobe and subtraction for an absent half-carry enable, which a design that treated them like their storing neighbours would get wrong. Shifts and rotates are checked with both carry values so a rotate that dropped the incoming carry, or a right shift that lost the sign bit, shows up, and random operands cover the rest.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBB = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_BTST = 5'd8,
        OP_NOT  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_CLR  = 5'd13,
        OP_TST  = 5'd14,
        OP_SHL  = 5'd15,
        OP_SAR  = 5'd16,
        OP_SHR  = 5'd17,
        OP_ROL  = 5'd18,
        OP_ROR  = 5'd19
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LEFT  = 3'd0,
        SH_ARITH = 3'd1,
        SH_LOGIC = 3'd2,
        SH_ROTL  = 3'd3,
        SH_ROTR  = 3'd4
    } shift_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_e;

    localparam int NFLAG = 5;
    localparam int FB_C  = 0;
    localparam int FB_Z  = 1;
    localparam int FB_N  = 2;
    localparam int FB_H  = 3;
    localparam int FB_V  = 4;

    localparam logic [NFLAG-1:0] EN_ALL   = 5'b11111;
    localparam logic [NFLAG-1:0] EN_VNZC  = 5'b10111;
    localparam logic [NFLAG-1:0] EN_VNZ   = 5'b10110;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         h_o,
    output logic         v_o
);
    localparam int HB = W / 2;

    logic [W:0]  full_d;
    logic [HB:0] low_d;

    always_comb begin
        if (sub_i) begin
            full_d = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            low_d  = '0;
        end else begin
            full_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            low_d  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
        end
        sum_o = full_d[W-1:0];
        c_o   = full_d[W];
        h_o   = low_d[HB];
        if (sub_i)
            v_o = (a_i[W-1] != b_i[W-1]) && (full_d[W-1] != a_i[W-1]);
        else
            v_o = (a_i[W-1] == b_i[W-1]) && (full_d[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   kind_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (logic_e'(kind_i))
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   kind_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    always_comb begin
        res_o  = b_i;
        cout_o = 1'b0;
        case (shift_e'(kind_i))
            SH_LEFT: begin
                res_o  = {b_i[W-2:0], 1'b0};
                cout_o = b_i[W-1];
            end
            SH_ARITH: begin
                res_o  = {b_i[W-1], b_i[W-1:1]};
                cout_o = b_i[0];
            end
            SH_LOGIC: begin
                res_o  = {1'b0, b_i[W-1:1]};
                cout_o = b_i[0];
            end
            SH_ROTL: begin
                res_o  = {b_i[W-2:0], cin_i};
                cout_o = b_i[W-1];
            end
            SH_ROTR: begin
                res_o  = {cin_i, b_i[W-1:1]};
                cout_o = b_i[0];
            end
            default: begin
                res_o  = b_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         op_i,
    input  logic [W-1:0]       acc_i,
    input  logic [W-1:0]       opd_i,
    input  logic               cin_i,
    output logic [W-1:0]       result_q,
    output logic               res_we_q,
    output logic [NFLAG-1:0]   flags_q,
    output logic [NFLAG-1:0]   fwe_q
);
    typedef struct packed {
        logic [W-1:0]     res;
        logic             we;
        logic [NFLAG-1:0] flg;
        logic [NFLAG-1:0] fwe;
    } alu_out_t;

    alu_op_e  op;
    alu_out_t nxt_d;
    alu_out_t out_q;

    assign op = alu_op_e'(op_i);

    // shared adder / subtractor operand selection
    logic [W-1:0] ar_a_d, ar_b_d, ar_sum;
    logic         ar_cin_d, ar_sub_d, ar_c, ar_h, ar_v;

    always_comb begin
        ar_a_d   = acc_i;
        ar_b_d   = opd_i;
        ar_cin_d = 1'b0;
        ar_sub_d = 1'b0;
        case (op)
            OP_ADDC: ar_cin_d = cin_i;
            OP_SUB, OP_CMP: ar_sub_d = 1'b1;
            OP_SUBB: begin
                ar_sub_d = 1'b1;
                ar_cin_d = cin_i;
            end
            OP_NEG: begin
                ar_a_d   = '0;
                ar_sub_d = 1'b1;
            end
            OP_INC: begin
                ar_a_d = opd_i;
                ar_b_d = W'(1);
            end
            OP_DEC: begin
                ar_a_d   = opd_i;
                ar_b_d   = W'(1);
                ar_sub_d = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .a_i   (ar_a_d),
        .b_i   (ar_b_d),
        .cin_i (ar_cin_d),
        .sub_i (ar_sub_d),
        .sum_o (ar_sum),
        .c_o   (ar_c),
        .h_o   (ar_h),
        .v_o   (ar_v)
    );

    logic [1:0]   lg_kind_d;
    logic [W-1:0] lg_res;

    always_comb begin
        case (op)
            OP_OR:   lg_kind_d = LG_OR;
            OP_XOR:  lg_kind_d = LG_XOR;
            default: lg_kind_d = LG_AND;
        endcase
    end

    alu8_logic #(.W(W)) u_logic (
        .kind_i (lg_kind_d),
        .a_i    (acc_i),
        .b_i    (opd_i),
        .res_o  (lg_res)
    );

    logic [2:0]   sh_kind_d;
    logic [W-1:0] sh_res;
    logic         sh_c;

    always_comb begin
        case (op)
            OP_SAR:  sh_kind_d = SH_ARITH;
            OP_SHR:  sh_kind_d = SH_LOGIC;
            OP_ROL:  sh_kind_d = SH_ROTL;
            OP_ROR:  sh_kind_d = SH_ROTR;
            default: sh_kind_d = SH_LEFT;
        endcase
    end

    alu8_shift #(.W(W)) u_shift (
        .kind_i (sh_kind_d),
        .b_i    (opd_i),
        .cin_i  (cin_i),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    // result, flag and enable selection
    always_comb begin
        logic [W-1:0]     r;
        logic             v, h, c, we;
        logic [NFLAG-1:0] en;
        r  = '0;
        v  = 1'b0;
        h  = 1'b0;
        c  = 1'b0;
        we = 1'b1;
        en = '0;
        case (op)
            OP_ADD, OP_ADDC: begin
                r  = ar_sum;
                v  = ar_v;
                h  = ar_h;
                c  = ar_c;
                en = EN_ALL;
            end
            OP_SUB, OP_SUBB, OP_CMP: begin
                r  = ar_sum;
                v  = ar_v;
                c  = ar_c;
                en = EN_VNZC;
                we = (op != OP_CMP);
            end
            OP_AND, OP_OR, OP_XOR, OP_BTST: begin
                r  = lg_res;
                en = EN_VNZ;
                we = (op != OP_BTST);
            end
            OP_NOT: begin
                r  = ~opd_i;
                c  = 1'b1;
                en = EN_VNZC;
            end
            OP_NEG: begin
                r  = ar_sum;
                v  = ar_v;
                c  = ar_c;
                en = EN_VNZC;
            end
            OP_INC, OP_DEC: begin
                r  = ar_sum;
                v  = ar_v;
                en = EN_VNZ;
            end
            OP_CLR: begin
                r  = '0;
                en = EN_VNZ;
            end
            OP_TST: begin
                r  = opd_i;
                en = EN_VNZ;
                we = 1'b0;
            end
            OP_SHL, OP_SAR, OP_SHR, OP_ROL, OP_ROR: begin
                r  = sh_res;
                c  = sh_c;
                v  = sh_res[W-1] ^ sh_c;
                en = EN_VNZC;
            end
            default: begin
                we = 1'b0;
                en = '0;
            end
        endcase
        nxt_d.res = r;
        nxt_d.we  = we;
        nxt_d.fwe = en;
        nxt_d.flg = {v, h, r[W-1], ~|r, c} & en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= nxt_d;
    end

    assign result_q = out_q.res;
    assign res_we_q = out_q.we;
    assign flags_q  = out_q.flg;
    assign fwe_q    = out_q.fwe;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       op_i,
    input logic [W-1:0]     result_q,
    input logic             res_we_q,
    input logic [NFLAG-1:0] flags_q,
    input logic [NFLAG-1:0] fwe_q
);
    // R2: a disabled flag never carries a 1
    p_masked_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~fwe_q) == '0);

    // R4: subtract family never writes H, always writes C
    p_sub_keeps_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(op_i) == OP_SUB || $past(op_i) == OP_SUBB || $past(op_i) == OP_CMP)
        |-> !fwe_q[FB_H] && fwe_q[FB_C]);

    // R5: flag-only operations do not request a store
    p_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(op_i) == OP_CMP || $past(op_i) == OP_BTST || $past(op_i) == OP_TST)
        |-> !res_we_q);

    // R7: complement forces carry and clears overflow
    p_not_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == OP_NOT |-> flags_q[FB_C] && !flags_q[FB_V]);

    // R9: increment and decrement leave carry alone
    p_incdec_keep_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC) |-> !fwe_q[FB_C]);

    // R10: clear yields zero with Z set
    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == OP_CLR |-> result_q == '0 && flags_q[FB_Z] && !flags_q[FB_N]);

    // R11: logical shift right leaves N clear
    p_shr_n_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == OP_SHR |-> !result_q[W-1] && !flags_q[FB_N]);

    // R13: shifts and rotates report V as N xor C
    p_shift_v_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) >= OP_SHL && $past(op_i) <= OP_ROR
        |-> flags_q[FB_V] == (flags_q[FB_N] ^ flags_q[FB_C]));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .result_q (result_q),
    .res_we_q (res_we_q),
    .flags_q  (flags_q),
    .fwe_q    (fwe_q)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    import alu8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opd_i = 8'd0;
    logic       cin_i = 1'b0;
    logic [7:0] result_q;
    logic       res_we_q;
    logic [4:0] flags_q;
    logic [4:0] fwe_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core #(.W(8)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opd_i    (opd_i),
        .cin_i    (cin_i),
        .result_q (result_q),
        .res_we_q (res_we_q),
        .flags_q  (flags_q),
        .fwe_q    (fwe_q)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1:          return "R3";
            2, 3, 4:       return "R4";
            5, 6, 7, 8:    return "R6";
            9:             return "R7";
            10:            return "R8";
            11, 12:        return "R9";
            13, 14:        return "R10";
            15, 16, 17:    return "R11";
            18, 19:        return "R12";
            default:       return "R2";
        endcase
    endfunction

    // expected {result, we, flags, enables} from the requirement text
    function automatic logic [18:0] model(input int op, input int a, input int b, input int c);
        int r, s, we, m, fv, fh, fc;
        r = 0; we = 1; m = 0; fv = 0; fh = 0; fc = 0;
        case (op)
            0, 1: begin
                s  = a + b + ((op == 1) ? c : 0);
                r  = s & 255;
                fc = (s > 255) ? 1 : 0;
                fh = (((a & 15) + (b & 15) + ((op == 1) ? c : 0)) > 15) ? 1 : 0;
                fv = ((~(a ^ b)) & (a ^ r) & 128) != 0 ? 1 : 0;
                m  = 31;
            end
            2, 3, 4: begin
                s  = a - b - ((op == 3) ? c : 0);
                r  = s & 255;
                fc = (s < 0) ? 1 : 0;
                fv = ((a ^ b) & (a ^ r) & 128) != 0 ? 1 : 0;
                m  = 23;
                we = (op == 4) ? 0 : 1;
            end
            5, 8: begin r = a & b; m = 22; we = (op == 8) ? 0 : 1; end
            6:    begin r = a | b; m = 22; end
            7:    begin r = a ^ b; m = 22; end
            9:    begin r = 255 - b; fc = 1; m = 23; end
            10: begin
                r  = (256 - b) & 255;
                fv = (b == 128) ? 1 : 0;
                fc = (b != 0) ? 1 : 0;
                m  = 23;
            end
            11: begin r = (b + 1) & 255; fv = (b == 127) ? 1 : 0; m = 22; end
            12: begin r = (b + 255) & 255; fv = (b == 128) ? 1 : 0; m = 22; end
            13: begin r = 0; m = 22; end
            14: begin r = b; m = 22; we = 0; end
            15, 16, 17, 18, 19: begin
                case (op)
                    15: begin r = (b << 1) & 255;          fc = b >> 7; end
                    16: begin r = (b >> 1) | (b & 128);     fc = b & 1;  end
                    17: begin r = b >> 1;                  fc = b & 1;  end
                    18: begin r = ((b << 1) | c) & 255;    fc = b >> 7; end
                    default: begin r = (b >> 1) | (c << 7); fc = b & 1; end
                endcase
                fv = ((r >> 7) & 1) ^ fc;
                m  = 23;
            end
            default: begin r = 0; m = 0; we = 0; end
        endcase
        return {r[7:0], we[0],
                (5'({fv[0], fh[0], r[7], (r == 0), fc[0]}) & m[4:0]), m[4:0]};
    endfunction

    task automatic compare(input string tag, input logic [18:0] exp);
        logic [18:0] act;
        act = {result_q, res_we_q, flags_q, fwe_q};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%h we=%b flg=%b en=%b expected res=%h we=%b flg=%b en=%b",
                     tag, act[18:11], act[10], act[9:5], act[4:0],
                     exp[18:11], exp[10], exp[9:5], exp[4:0]);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic run_op(input int op, input int a, input int b, input int c);
        @(negedge clk);
        op_i  = 5'(op);
        acc_i = 8'(a);
        opd_i = 8'(b);
        cin_i = c[0];
        @(negedge clk);
        compare(tag_of(op), model(op, a, b, c));
    endtask

    // expectation written by hand rather than from the model
    task automatic run_fixed(input string tag, input int op, input int a, input int b, input int c,
                             input logic [18:0] exp);
        @(negedge clk);
        op_i  = 5'(op);
        acc_i = 8'(a);
        opd_i = 8'(b);
        cin_i = c[0];
        @(negedge clk);
        compare(tag, exp);
    endtask

    task automatic t_reset;
        // R1: outputs zero under reset even with live inputs
        op_i = OP_NOT; opd_i = 8'h12; cin_i = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", {8'hED, 1'b1, 5'b00101, 5'b10111});
    endtask

    task automatic t_add;
        // R3: 7F+01 -> 80, V H N set
        run_fixed("R3", OP_ADD, 8'h7F, 8'h01, 0, {8'h80, 1'b1, 5'b11100, 5'b11111});
        // R3: FF+01 -> 00, H Z C set
        run_fixed("R3", OP_ADD, 8'hFF, 8'h01, 0, {8'h00, 1'b1, 5'b01011, 5'b11111});
        // R3: 0F+00+C -> 10, H from carry in
        run_fixed("R3", OP_ADDC, 8'h0F, 8'h00, 1, {8'h10, 1'b1, 5'b01000, 5'b11111});
        run_op(OP_ADD, 8'h80, 8'h80, 1);
        run_op(OP_ADDC, 8'h7F, 8'h00, 1);
    endtask

    task automatic t_sub;
        // R4: 00-01 -> FF with borrow, H not enabled
        run_fixed("R4", OP_SUB, 8'h00, 8'h01, 0, {8'hFF, 1'b1, 5'b00101, 5'b10111});
        // R4: 80-01 -> 7F overflow
        run_fixed("R4", OP_SUBB, 8'h80, 8'h00, 1, {8'h7F, 1'b1, 5'b10000, 5'b10111});
        // R4 and R5: compare equal, no store
        run_fixed("R5", OP_CMP, 8'h42, 8'h42, 1, {8'h00, 1'b0, 5'b00010, 5'b10111});
    endtask

    task automatic t_logic;
        // R6: bit test computes AND, no store
        run_fixed("R6", OP_BTST, 8'hF0, 8'h0F, 1, {8'h00, 1'b0, 5'b00010, 5'b10110});
        run_op(OP_AND, 8'hC3, 8'h81, 0);
        run_op(OP_OR, 8'h40, 8'h81, 1);
        run_op(OP_XOR, 8'hFF, 8'hFF, 0);
    endtask

    task automatic t_unary;
        // R7
        run_fixed("R7", OP_NOT, 0, 8'hFF, 0, {8'h00, 1'b1, 5'b00011, 5'b10111});
        // R8
        run_fixed("R8", OP_NEG, 0, 8'h80, 0, {8'h80, 1'b1, 5'b10101, 5'b10111});
        run_fixed("R8", OP_NEG, 0, 8'h00, 1, {8'h00, 1'b1, 5'b00010, 5'b10111});
        // R9
        run_fixed("R9", OP_INC, 0, 8'h7F, 1, {8'h80, 1'b1, 5'b10100, 5'b10110});
        run_fixed("R9", OP_DEC, 0, 8'h80, 1, {8'h7F, 1'b1, 5'b10000, 5'b10110});
        // R10
        run_fixed("R10", OP_CLR, 8'h55, 8'hAA, 1, {8'h00, 1'b1, 5'b00010, 5'b10110});
        run_fixed("R10", OP_TST, 0, 8'h9C, 1, {8'h9C, 1'b0, 5'b00100, 5'b10110});
    endtask

    task automatic t_shift;
        // R11 and R13: ASR of 81 keeps sign, C=1, V=N^C=0
        run_fixed("R11", OP_SAR, 0, 8'h81, 0, {8'hC0, 1'b1, 5'b00101, 5'b10111});
        // R11 and R13: LSR of 01 -> 00, C=1, V=1
        run_fixed("R13", OP_SHR, 0, 8'h01, 0, {8'h00, 1'b1, 5'b10011, 5'b10111});
        // R12: ROL pulls carry in
        run_fixed("R12", OP_ROL, 0, 8'h80, 1, {8'h01, 1'b1, 5'b10001, 5'b10111});
        run_fixed("R12", OP_ROR, 0, 8'h02, 1, {8'h81, 1'b1, 5'b10100, 5'b10111});
        run_op(OP_SHL, 0, 8'h40, 1);
    endtask

    task automatic t_undefined;
        // R2: unused codes do nothing
        for (int k = 20; k < 32; k++)
            run_op(k, 8'hFF, 8'hFF, 1);
    endtask

    task automatic t_corners;
        int edges[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        for (int op = 0; op < 20; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int c = 0; c < 2; c++)
                        run_op(op, edges[i], edges[j], c);
    endtask

    task automatic t_random;
        for (int n = 0; n < 3000; n++)
            run_op(int'($urandom_range(19, 0)), int'($urandom_range(255, 0)),
                   int'($urandom_range(255, 0)), int'($urandom_range(1, 0)));
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_unary();
        t_shift();
        t_undefined();
        t_corners();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule